// File: doc/BRIEF.md
# Escaped Byte Stream Decoder

This block turns an 8-bit byte stream that carries escape sequences back into 9-bit link symbols. A byte that needs no special treatment leaves as a symbol with bit 8 clear. A marker byte opens an escape sequence. The marker itself is swallowed. The byte after it is checked for a fixed layout and then decoded. The result is either a comma symbol with bit 8 set, or one of four reserved byte values restored as a literal. The three flow-control and padding values can only appear on the line as transport artefacts when they arrive raw, so the decoder drops them.

Bytes enter through an enable/busy handshake. Symbols leave through a valid/hold handshake from a single output register. Busy is raised only while a symbol sits in that register and the consumer holds it. A symbol can therefore drain and a new byte can be taken on the same edge, with no bubble. Any malformed escape sequence gives a one-cycle error pulse.

The control is a two-state machine. IDLE_ST handles plain bytes. ESC_PEND_ST means a marker has been seen. There are four transitions. "mark" goes from IDLE_ST to ESC_PEND_ST when the marker arrives. "decode" goes from ESC_PEND_ST to IDLE_ST on a well-formed code byte. "reject" goes from ESC_PEND_ST to IDLE_ST on a malformed byte. "re-escape" stays in ESC_PEND_ST when a second marker arrives.

Top module: `esc_stream_decoder`

## Requirements
- R1: While reset is high and on the first cycle after it, sym_vld is 0, err is 0 and no escape is pending, so the first byte is treated as a plain byte.
- R2: A byte accepted in IDLE_ST that is not 0xCA, 0x11, 0x13 or 0x47 appears on the next cycle as sym_data = {1'b0, byte} with sym_vld = 1.
- R3: The marker byte 0xCA accepted in IDLE_ST produces no symbol and no error, and the next accepted byte is decoded as a code byte.
- R4: A code byte is well formed only if bits 7..6 equal 2'b01 and bits 5..3 equal the bitwise inverse of bits 2..0. Any other byte (other than 0xCA) in ESC_PEND_ST gives err = 1 for exactly the next cycle, produces no symbol and returns to IDLE_ST.
- R5: Well-formed codes 0..3 produce the comma symbol {1'b1, 5'b00000, code[2:0]} on the next cycle.
- R6: Well-formed codes 4, 5, 6 and 7 produce the literal symbols 0x011, 0x013, 0x047 and 0x0CA, with bit 8 clear.
- R7: Raw bytes 0x11, 0x13 and 0x47 accepted in IDLE_ST are dropped: no symbol and no error.
- R8: A 0xCA accepted in ESC_PEND_ST gives a one-cycle error pulse and the block stays in ESC_PEND_ST, so the next well-formed code byte is still decoded.
- R9: A byte transfers only on an edge where byte_en = 1 and byte_busy = 0. A symbol transfers on an edge where sym_vld = 1 and sym_hold = 0. byte_busy = sym_vld AND sym_hold, and a held symbol stays unchanged.
- R10: If a symbol drains and a new byte is accepted on the same edge, the new symbol is valid on the next cycle with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| byte_en | input | 1 | Input byte offered |
| byte_data | input | 8 | Escaped input byte |
| byte_busy | output | 1 | Input stalled; byte not taken this cycle |
| sym_vld | output | 1 | Output symbol present |
| sym_data | output | 9 | Rebuilt link symbol |
| sym_hold | input | 1 | Consumer refuses the symbol this cycle |
| err | output | 1 | One-cycle pulse on a malformed escape sequence |

## Verification
Two functions can fall in the same cycle. One is the drain of the held symbol. The other is the acceptance of a new byte that replaces it, or that raises an error or is dropped while the old symbol leaves. The bench provokes this by dropping sym_hold while byte_en is high and a symbol is waiting, in directed sequences and under random hold and enable patterns. It judges the result against a cycle model built from the requirements, which checks that the old symbol is not repeated, that the new one arrives on the very next cycle, and that busy follows hold exactly.

// File: rtl/esc_dec_pkg.sv
package esc_dec_pkg;
    localparam int BYTE_W = 8;
    localparam int SYM_W  = BYTE_W + 1;
    localparam int CODE_W = 3;
    localparam int PFX_W  = BYTE_W - 2 * CODE_W;

    localparam logic [BYTE_W-1:0] MARK_BYTE = 8'hCA;
    localparam logic [BYTE_W-1:0] XON_BYTE  = 8'h11;
    localparam logic [BYTE_W-1:0] XOFF_BYTE = 8'h13;
    localparam logic [BYTE_W-1:0] PAD_BYTE  = 8'h47;
    localparam logic [PFX_W-1:0]  CODE_PFX  = 2'b01;

    typedef enum logic {
        IDLE_ST     = 1'b0,
        ESC_PEND_ST = 1'b1
    } dec_state_t;
endpackage

// File: rtl/esc_code_decode.sv
module esc_code_decode
    import esc_dec_pkg::*;
(
    input  logic [BYTE_W-1:0] code_byte,
    output logic              fmt_ok,
    output logic [SYM_W-1:0]  code_sym
);
    logic [CODE_W-1:0] code;
    logic [CODE_W-1:0] code_n;
    logic [PFX_W-1:0]  pfx;
    logic [BYTE_W-1:0] lit;

    assign code   = code_byte[CODE_W-1:0];
    assign code_n = code_byte[2*CODE_W-1:CODE_W];
    assign pfx    = code_byte[BYTE_W-1:2*CODE_W];

    assign fmt_ok = (pfx == CODE_PFX) && (code_n == ~code);

    always_comb begin
        unique case (code[1:0])
            2'd0:    lit = XON_BYTE;
            2'd1:    lit = XOFF_BYTE;
            2'd2:    lit = PAD_BYTE;
            default: lit = MARK_BYTE;
        endcase
    end

    always_comb begin
        if (code[CODE_W-1]) begin
            code_sym = {1'b0, lit};
        end else begin
            code_sym = '0;
            code_sym[SYM_W-1]    = 1'b1;
            code_sym[CODE_W-1:0] = code;
        end
    end
endmodule

// File: rtl/sym_hold_reg.sv
module sym_hold_reg
    import esc_dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [SYM_W-1:0] load_sym,
    input  logic             hold,
    output logic             vld,
    output logic [SYM_W-1:0] sym
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= 1'b0;
            sym <= '0;
        end else begin
            if (load) begin
                vld <= 1'b1;
                sym <= load_sym;
            end else begin
                vld <= vld && hold;
            end
        end
    end

    // R9: a symbol refused by the consumer stays put
    a_r9_held_stable: assert property (@(posedge clk) disable iff (rst)
        (vld && hold) |=> (vld && $stable(sym)));

    // R10: loading while the old symbol drains yields a valid symbol next cycle
    a_r10_reload: assert property (@(posedge clk) disable iff (rst)
        (load && vld && !hold) |=> vld);
endmodule

// File: rtl/esc_stream_decoder.sv
module esc_stream_decoder
    import esc_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_en,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              byte_busy,
    output logic              sym_vld,
    output logic [SYM_W-1:0]  sym_data,
    input  logic              sym_hold,
    output logic              err
);
    dec_state_t       state_q;
    dec_state_t       state_d;
    logic             acc;
    logic             fmt_ok;
    logic [SYM_W-1:0] code_sym;
    logic             emit;
    logic [SYM_W-1:0] emit_sym;
    logic             err_d;
    logic             is_mark;
    logic             is_artefact;

    assign byte_busy   = sym_vld && sym_hold;
    assign acc         = byte_en && !byte_busy;
    assign is_mark     = (byte_data == MARK_BYTE);
    assign is_artefact = (byte_data == XON_BYTE) || (byte_data == XOFF_BYTE) ||
                         (byte_data == PAD_BYTE);

    esc_code_decode u_code (
        .code_byte (byte_data),
        .fmt_ok    (fmt_ok),
        .code_sym  (code_sym)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= IDLE_ST;
            err     <= 1'b0;
        end else begin
            state_q <= state_d;
            err     <= err_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        emit     = 1'b0;
        emit_sym = {1'b0, byte_data};
        err_d    = 1'b0;
        if (acc) begin
            unique case (state_q)
                IDLE_ST: begin
                    if (is_mark) begin
                        state_d = ESC_PEND_ST;            // mark
                    end else if (!is_artefact) begin
                        emit = 1'b1;
                    end
                end
                ESC_PEND_ST: begin
                    if (is_mark) begin
                        err_d = 1'b1;                     // re-escape
                    end else if (fmt_ok) begin
                        state_d  = IDLE_ST;               // decode
                        emit     = 1'b1;
                        emit_sym = code_sym;
                    end else begin
                        state_d = IDLE_ST;                // reject
                        err_d   = 1'b1;
                    end
                end
                default: state_d = IDLE_ST;
            endcase
        end
    end

    sym_hold_reg u_out (
        .clk      (clk),
        .rst      (rst),
        .load     (emit),
        .load_sym (emit_sym),
        .hold     (sym_hold),
        .vld      (sym_vld),
        .sym      (sym_data)
    );

    // R4: an error pulse follows an accepted byte
    a_r4_err_after_accept: assert property (@(posedge clk) disable iff (rst)
        err |-> $past(acc));

    // R5: comma symbols carry zeros between bit 8 and the code
    a_r5_comma_shape: assert property (@(posedge clk) disable iff (rst)
        (sym_vld && sym_data[SYM_W-1]) |-> (sym_data[BYTE_W-1:CODE_W] == '0));

    // R3: a marker taken in IDLE_ST opens an escape and emits nothing
    a_r3_mark_pends: assert property (@(posedge clk) disable iff (rst)
        (acc && is_mark && state_q == IDLE_ST) |=> (state_q == ESC_PEND_ST && !err));

    // R8: a second marker keeps the escape pending
    a_r8_reescape: assert property (@(posedge clk) disable iff (rst)
        (acc && is_mark && state_q == ESC_PEND_ST) |=> (state_q == ESC_PEND_ST && err));

    // R9: a newly valid symbol needs an accepted byte
    a_r9_vld_source: assert property (@(posedge clk) disable iff (rst)
        $rose(sym_vld) |-> $past(acc));
endmodule

// File: tb/sim_esc_stream_decoder.sv
module sim_esc_stream_decoder;
    logic       clk = 1'b0;
    logic       rst;
    logic       byte_en;
    logic [7:0] byte_data;
    logic       byte_busy;
    logic       sym_vld;
    logic [8:0] sym_data;
    logic       sym_hold;
    logic       err;

    int checks = 0;
    int errors = 0;

    logic       m_vld, m_pend, m_err;
    logic [8:0] m_sym;

    always #10 clk = ~clk;

    esc_stream_decoder u0 (
        .clk       (clk),
        .rst       (rst),
        .byte_en   (byte_en),
        .byte_data (byte_data),
        .byte_busy (byte_busy),
        .sym_vld   (sym_vld),
        .sym_data  (sym_data),
        .sym_hold  (sym_hold),
        .err       (err)
    );

    function automatic logic good_code(input logic [7:0] b);
        return (b[7:6] == 2'b01) && (b[5:3] == ~b[2:0]);
    endfunction

    function automatic logic [8:0] decode_code(input logic [2:0] c);
        case (c)
            3'd4:    return 9'h011;
            3'd5:    return 9'h013;
            3'd6:    return 9'h047;
            3'd7:    return 9'h0CA;
            default: return {1'b1, 5'b0, c};
        endcase
    endfunction

    function automatic logic [7:0] mk_code(input logic [2:0] c);
        return {2'b01, ~c, c};
    endfunction

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic en, input logic [7:0] b, input logic hold);
        logic acc, emit, nerr;
        logic [8:0] nsym;
        @(negedge clk);
        chk("R9/R10 sym_vld", {8'd0, sym_vld}, {8'd0, m_vld});
        if (m_vld) chk("R2/R5/R6 sym_data", sym_data, m_sym);
        chk("R4/R8 err", {8'd0, err}, {8'd0, m_err});
        byte_en = en; byte_data = b; sym_hold = hold;
        #1;
        chk("R9 byte_busy", {8'd0, byte_busy}, {8'd0, m_vld && hold});
        acc = en && !(m_vld && hold);
        emit = 1'b0; nerr = 1'b0; nsym = {1'b0, b};
        if (acc) begin
            if (!m_pend) begin
                if (b == 8'hCA) m_pend = 1'b1;
                else if (b != 8'h11 && b != 8'h13 && b != 8'h47) emit = 1'b1;
            end else begin
                if (b == 8'hCA) nerr = 1'b1;
                else if (good_code(b)) begin
                    m_pend = 1'b0; emit = 1'b1; nsym = decode_code(b[2:0]);
                end else begin
                    m_pend = 1'b0; nerr = 1'b1;
                end
            end
        end
        if (emit) begin m_vld = 1'b1; m_sym = nsym; end
        else m_vld = m_vld && hold;
        m_err = nerr;
    endtask

    function automatic logic [7:0] rand_byte();
        int r = $urandom % 8;
        case (r)
            0, 1: return 8'hCA;
            2, 3: return mk_code(3'($urandom));
            4: begin
                int t = $urandom % 3;
                return (t == 0) ? 8'h11 : (t == 1) ? 8'h13 : 8'h47;
            end
            5: return {2'b01, 6'($urandom)};
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        rst = 1'b1; byte_en = 1'b0; byte_data = 8'h00; sym_hold = 1'b0;
        m_vld = 1'b0; m_pend = 1'b0; m_err = 1'b0; m_sym = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset sym_vld", {8'd0, sym_vld}, 9'd0);
        chk("R1 reset err", {8'd0, err}, 9'd0);
        rst = 1'b0;
        // R1: first byte after reset is a plain byte
        step(1'b1, 8'h55, 1'b0);
        // R2: plain bytes back to back
        step(1'b1, 8'hA0, 1'b0);
        step(1'b0, 8'h00, 1'b0);
        // R3/R5/R6: every code after a marker
        for (int c = 0; c < 8; c++) begin
            step(1'b1, 8'hCA, 1'b0);
            step(1'b1, mk_code(3'(c)), 1'b0);
        end
        // R7: raw artefacts dropped
        step(1'b1, 8'h11, 1'b0);
        step(1'b1, 8'h13, 1'b0);
        step(1'b1, 8'h47, 1'b0);
        // R4: malformed code byte
        step(1'b1, 8'hCA, 1'b0);
        step(1'b1, 8'h7F, 1'b0);
        step(1'b1, 8'h66, 1'b0);
        // R8: marker twice then valid code
        step(1'b1, 8'hCA, 1'b0);
        step(1'b1, 8'hCA, 1'b0);
        step(1'b1, mk_code(3'd1), 1'b0);
        // R9: held symbol stalls input; R10: drain and accept together
        step(1'b1, 8'h21, 1'b1);
        step(1'b1, 8'h22, 1'b1);
        step(1'b1, 8'h22, 1'b1);
        step(1'b1, 8'h22, 1'b0);
        step(1'b1, 8'h23, 1'b0);
        step(1'b0, 8'h00, 1'b0);
        // random mix
        for (int i = 0; i < 20000; i++) begin
            step(($urandom % 5) != 0, rand_byte(), ($urandom % 10) < 3);
        end
        step(1'b0, 8'h00, 1'b0);
        step(1'b0, 8'h00, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule